// File: doc/BRIEF.md
# Serial Command Front End for a Quad Digital Potentiometer

This block is the serial-port face of a four-channel digital potentiometer controller. A host talks to it as a mode-0 SPI slave: the slave takes data from the host on the rising edge of the serial clock and presents its own output bit after each falling edge. The output pin is released (output enable low) whenever the chip select is high. All four port lines are brought into the system clock with synchronizer chains, and every later decision is made in that one clock domain. The block therefore hands a register bank clean single-cycle strobes.

The first byte after chip select falls is an instruction. Bits 7:4 carry the operation, bits 3:2 a device address that must equal the two strap pins, and bits 1:0 select one of the four potentiometers. The operation sets how many further bytes follow: an optional register-address byte, then a write-data byte or a read-data byte. A hold input can freeze a sequence part way through and later resume it from the same bit.

Top module: `spi_pot_slave`

## Requirements
- R1: SI is taken on each rising SCK, MSB first. In the instruction byte, bits 7:4 are the operation, bits 3:2 the device address and bits 1:0 the pot select (cmd_op, cmd_pot). The register-address byte goes to cmd_addr and the write-data byte to cmd_data. Both are zero for operations that carry no such byte.
- R2: Read data is shifted out MSB first. The first bit appears after the falling SCK that follows the last rising SCK of the request. spi_so changes only after a falling SCK.
- R3: spi_so_oe is low while chip select is high and outside the read-data phase of an accepted read. It is high during that phase.
- R4: A sequence starts only after chip select falls. A rising chip select at any point clears the bit and byte counters, so a cut-off sequence leaves no trace and the next one starts afresh.
- R5: Exactly six operation codes are accepted: 9 read wiper, A write wiper, B read register, C write register, D load register into wiper, E save wiper into register. Any other code makes the slave ignore the rest of the frame until chip select rises.
- R6: A command is acted on only when instruction bits 3:2 equal strap_addr. Otherwise neither cmd_valid nor rd_req is raised.
- R7: A pause begins when spi_hold_n is low while SCK is low. During the pause, SCK and SI are ignored and spi_so_oe is low. The pause ends when spi_hold_n is high while SCK is low, and shifting then continues from the saved bit.
- R8: Write and transfer commands raise cmd_valid for exactly one clock after chip select rises. The fields stay on cmd_op, cmd_pot, cmd_addr and cmd_data.
- R9: Read commands raise rd_req for one clock as soon as their last request byte has been taken in (byte 1 for 9, byte 2 for B). cmd_pot and cmd_addr are valid in that cycle, and rd_data is sampled at the next falling SCK.
- R10: A frame whose length in whole bytes is not exactly 2 (codes 9, A, D, E) or 3 (codes B, C), or that ends part way through a byte, raises no cmd_valid.
- R11: After reset, spi_so_oe, cmd_valid and rd_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from host |
| spi_hold_n | input | 1 | Pause request, active low |
| strap_addr | input | 2 | Device address straps |
| rd_data | input | 8 | Read data from register bank |
| spi_so | output | 1 | Serial data to host |
| spi_so_oe | output | 1 | Output enable for spi_so (low = high impedance) |
| cmd_valid | output | 1 | One-clock strobe for a completed write or transfer |
| rd_req | output | 1 | One-clock strobe requesting read data |
| cmd_op | output | 4 | Operation code |
| cmd_pot | output | 2 | Potentiometer select |
| cmd_addr | output | 8 | Register address byte |
| cmd_data | output | 8 | Write data byte |

## Verification
The bench builds the block with its defaults: an 8-bit byte, two synchronizer stages and a 3-bit byte counter that saturates at 7. With these values, frames of one to three bytes and over-long frames all fit in a short run. The serial clock runs at one sixteenth of the system clock, which leaves room to see each output bit settle after the synchronizer latency. That margin also lets a hold pause be placed between any two bits of a request byte or of a read-data byte.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_RD_WIPER = 4'h9,
    OP_WR_WIPER = 4'hA,
    OP_RD_REG   = 4'hB,
    OP_WR_REG   = 4'hC,
    OP_LOAD     = 4'hD,
    OP_SAVE     = 4'hE
  } op_e;

  typedef struct packed {
    logic known;
    logic has_addr;
    logic has_wdata;
    logic is_read;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [3:0] op);
    op_info_t i;
    i = '0;
    case (op)
      OP_RD_WIPER: i = '{known: 1'b1, has_addr: 1'b0, has_wdata: 1'b0, is_read: 1'b1};
      OP_WR_WIPER: i = '{known: 1'b1, has_addr: 1'b0, has_wdata: 1'b1, is_read: 1'b0};
      OP_RD_REG:   i = '{known: 1'b1, has_addr: 1'b1, has_wdata: 1'b0, is_read: 1'b1};
      OP_WR_REG:   i = '{known: 1'b1, has_addr: 1'b1, has_wdata: 1'b1, is_read: 1'b0};
      OP_LOAD:     i = '{known: 1'b1, has_addr: 1'b1, has_wdata: 1'b0, is_read: 1'b0};
      OP_SAVE:     i = '{known: 1'b1, has_addr: 1'b1, has_wdata: 1'b0, is_read: 1'b0};
      default:     i = '0;
    endcase
    return i;
  endfunction

  // Whole bytes in a well-formed frame, instruction included.
  function automatic logic [2:0] frame_len(input op_info_t i);
    return 3'd1 + {2'b00, i.has_addr} + {2'b00, (i.has_wdata | i.is_read)};
  endfunction

endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_pot_edge.sv
module spi_pot_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic paused
);

  logic sck_q, cs_q, live;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      paused <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      if (cs_n_s)      paused <= 1'b0;
      else if (!sck_s) paused <= !hold_n_s;
    end
  end

  assign live     = !cs_n_s && !paused;
  assign sck_rise = live &&  sck_s && !sck_q;
  assign sck_fall = live && !sck_s &&  sck_q;
  assign cs_rise  = cs_n_s && !cs_q;

  p_pause_entry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(paused) |-> !$past(sck_s));
  p_pause_exit_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(paused) |-> ($past(cs_n_s) || !$past(sck_s)));

endmodule

// File: rtl/spi_pot_frame.sv
module spi_pot_frame
  import spi_pot_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              si_s,
  input  logic              sck_rise,
  input  logic              cs_rise,
  input  logic [1:0]        strap,
  output logic              cmd_valid,
  output logic              rd_req,
  output logic              rd_phase,
  output logic [3:0]        cmd_op,
  output logic [1:0]        cmd_pot,
  output logic [BYTE_W-1:0] cmd_addr,
  output logic [BYTE_W-1:0] cmd_data
);

  localparam int              BIT_W    = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);
  localparam logic [BIT_W-1:0] BIT_ONE  = BIT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [BYTE_W-2:0] shreg;
  logic [BIT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  byte_cnt;
  logic              accepted;
  logic [BYTE_W-1:0] byte_in;
  logic              byte_done;
  op_info_t          info, new_info;
  logic [CNT_W-1:0]  exp_len;
  logic              match;

  assign byte_in   = {shreg, si_s};
  assign byte_done = sck_rise && (bit_cnt == BIT_LAST);
  assign info      = decode_op(cmd_op);
  assign new_info  = decode_op(byte_in[BYTE_W-1:BYTE_W-4]);
  assign exp_len   = CNT_W'(frame_len(info));
  assign match     = new_info.known && (byte_in[3:2] == strap);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      accepted  <= 1'b0;
      rd_phase  <= 1'b0;
      cmd_valid <= 1'b0;
      rd_req    <= 1'b0;
      cmd_op    <= '0;
      cmd_pot   <= '0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      rd_req    <= 1'b0;
      if (cs_rise)
        cmd_valid <= accepted && info.known && !info.is_read &&
                     (bit_cnt == '0) && (byte_cnt == exp_len);
      if (cs_n_s) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        accepted <= 1'b0;
        rd_phase <= 1'b0;
      end else if (sck_rise) begin
        shreg   <= byte_in[BYTE_W-2:0];
        bit_cnt <= byte_done ? '0 : bit_cnt + BIT_ONE;
        if (byte_done) begin
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + CNT_ONE;
          if (byte_cnt == '0) begin
            accepted <= match;
            if (match) begin
              cmd_op   <= byte_in[BYTE_W-1:BYTE_W-4];
              cmd_pot  <= byte_in[1:0];
              cmd_addr <= '0;
              cmd_data <= '0;
              if (new_info.is_read && !new_info.has_addr) begin
                rd_req   <= 1'b1;
                rd_phase <= 1'b1;
              end
            end
          end else if (accepted) begin
            if (byte_cnt == CNT_ONE && info.has_addr) begin
              cmd_addr <= byte_in;
              if (info.is_read) begin
                rd_req   <= 1'b1;
                rd_phase <= 1'b1;
              end
            end else if (info.has_wdata && byte_cnt == exp_len - CNT_ONE) begin
              cmd_data <= byte_in;
            end
          end
        end
      end
    end
  end

  p_cs_high_idle_r4: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (bit_cnt == '0 && byte_cnt == '0 && !rd_phase));
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  p_valid_after_cs_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(cs_rise));
  p_rdreq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  p_rdreq_needs_select_r4: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !$past(cs_n_s));

endmodule

// File: rtl/spi_pot_so.sv
module spi_pot_so #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              paused,
  input  logic              rd_phase,
  input  logic              sck_fall,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              so,
  output logic              so_oe
);

  logic [BYTE_W-1:0] sh;
  logic              loaded;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      loaded <= 1'b0;
      so     <= 1'b0;
      so_oe  <= 1'b0;
    end else begin
      so_oe <= !cs_n_s && !paused && (loaded || (rd_phase && sck_fall));
      if (cs_n_s) begin
        loaded <= 1'b0;
        sh     <= '0;
      end else if (sck_fall && rd_phase) begin
        if (!loaded) begin
          so     <= rd_data[BYTE_W-1];
          sh     <= {rd_data[BYTE_W-2:0], 1'b0};
          loaded <= 1'b1;
        end else begin
          so <= sh[BYTE_W-1];
          sh <= {sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  p_so_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(sck_fall) |-> $stable(so));
  p_oe_off_deselect_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !so_oe);
  p_oe_off_pause_r7: assert property (@(posedge clk) disable iff (rst)
    paused |=> !so_oe);

endmodule

// File: rtl/spi_pot_slave.sv
module spi_pot_slave
  import spi_pot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  input  logic [1:0]        strap_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              cmd_valid,
  output logic              rd_req,
  output logic [3:0]        cmd_op,
  output logic [1:0]        cmd_pot,
  output logic [BYTE_W-1:0] cmd_addr,
  output logic [BYTE_W-1:0] cmd_data
);

  logic [3:0] pins_s;
  logic sck_s, si_s, cs_n_s, hold_n_s;
  logic sck_rise, sck_fall, cs_rise, paused, rd_phase;

  spi_pot_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_hold_n, spi_cs_n, spi_si, spi_sck}),
    .q   (pins_s)
  );
  assign {hold_n_s, cs_n_s, si_s, sck_s} = pins_s;

  spi_pot_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (sck_s),
    .cs_n_s   (cs_n_s),
    .hold_n_s (hold_n_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise),
    .paused   (paused)
  );

  spi_pot_frame #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (cs_n_s),
    .si_s      (si_s),
    .sck_rise  (sck_rise),
    .cs_rise   (cs_rise),
    .strap     (strap_addr),
    .cmd_valid (cmd_valid),
    .rd_req    (rd_req),
    .rd_phase  (rd_phase),
    .cmd_op    (cmd_op),
    .cmd_pot   (cmd_pot),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  spi_pot_so #(.BYTE_W(BYTE_W)) u_so (
    .clk      (clk),
    .rst      (rst),
    .cs_n_s   (cs_n_s),
    .paused   (paused),
    .rd_phase (rd_phase),
    .sck_fall (sck_fall),
    .rd_data  (rd_data),
    .so       (spi_so),
    .so_oe    (spi_so_oe)
  );

  p_no_strobe_in_reset_r11: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_valid && !rd_req && !spi_so_oe));

endmodule

// File: tb/spi_pot_slave_bench.sv
module spi_pot_slave_bench;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1;
  logic [1:0] strap_addr = 2'b10;
  logic [7:0] rd_data;
  logic spi_so, spi_so_oe, cmd_valid, rd_req;
  logic [3:0] cmd_op;
  logic [1:0] cmd_pot;
  logic [7:0] cmd_addr, cmd_data;

  int checks = 0, failures = 0;
  int vcnt = 0, rcnt = 0;
  logic [3:0] v_op;
  logic [1:0] v_pot;
  logic [7:0] v_addr, v_data;

  always #2.5 clk = ~clk;

  // register-bank model: read data derived from the request fields
  assign rd_data = {cmd_pot, cmd_addr[5:0]} ^ 8'hA5;

  spi_pot_slave u_spi_pot_slave (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_hold_n(spi_hold_n), .strap_addr(strap_addr),
    .rd_data(rd_data), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .cmd_valid(cmd_valid), .rd_req(rd_req), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always @(posedge clk) begin
    if (cmd_valid) begin
      vcnt <= vcnt + 1;
      v_op <= cmd_op; v_pot <= cmd_pot; v_addr <= cmd_addr; v_data <= cmd_data;
    end
    if (rd_req) rcnt <= rcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic r, output logic oe, output logic stab);
    spi_si = b;
    wait_clk(HALF);
    r = spi_so; oe = spi_so_oe;
    spi_sck = 1'b1;
    wait_clk(HALF);
    stab = (spi_so == r);
    spi_sck = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] b, output logic [7:0] rx,
                           output logic oe_all, output logic stab_all);
    oe_all = 1'b1; stab_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic r, oe, st;
      xfer_bit(b[i], r, oe, st);
      rx[i] = r; oe_all &= oe; stab_all &= st;
    end
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, input int n, output logic [7:0] last_rx,
                       output logic oe_last, output logic stab_last);
    logic [7:0] rx;
    logic oe, st;
    cs_begin();
    xfer_byte(b0, rx, oe, st);
    if (n > 1) xfer_byte(b1, rx, oe, st);
    if (n > 2) xfer_byte(b2, rx, oe, st);
    last_rx = rx; oe_last = oe; stab_last = st;
    cs_end();
  endtask

  typedef struct packed {
    logic [7:0] b0, b1, b2;
    logic [1:0] n;
    logic       exp;
    logic [3:0] op;
    logic [1:0] pot;
    logic [7:0] addr, data;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'hA9, 8'h3F, 8'h00, 2'd2, 1'b1, 4'hA, 2'd1, 8'h00, 8'h3F}, // R1 R8 write wiper
    '{8'hCB, 8'h0E, 8'h2A, 2'd3, 1'b1, 4'hC, 2'd3, 8'h0E, 8'h2A}, // R1 R8 write register
    '{8'hD8, 8'h05, 8'h00, 2'd2, 1'b1, 4'hD, 2'd0, 8'h05, 8'h00}, // R5 load
    '{8'hEA, 8'h07, 8'h00, 2'd2, 1'b1, 4'hE, 2'd2, 8'h07, 8'h00}, // R5 save
    '{8'hA5, 8'h11, 8'h00, 2'd2, 1'b0, 4'h0, 2'd0, 8'h00, 8'h00}, // R6 wrong device
    '{8'h38, 8'hA9, 8'h10, 2'd3, 1'b0, 4'h0, 2'd0, 8'h00, 8'h00}, // R5 unknown code
    '{8'hCB, 8'h01, 8'h00, 2'd2, 1'b0, 4'h0, 2'd0, 8'h00, 8'h00}, // R10 short
    '{8'hA8, 8'h3C, 8'h55, 2'd3, 1'b0, 4'h0, 2'd0, 8'h00, 8'h00}, // R10 long
    '{8'hF8, 8'h01, 8'h00, 2'd2, 1'b0, 4'h0, 2'd0, 8'h00, 8'h00}  // R5 code F
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic oe, st, r;
    int v0, r0;

    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R11 reset state
    chk(!spi_so_oe && !cmd_valid && !rd_req, "R11 reset outputs", {spi_so_oe, cmd_valid, rd_req}, 0);
    // R3 deselected
    chk(!spi_so_oe, "R3 oe while cs high", spi_so_oe, 0);

    for (int k = 0; k < 9; k++) begin
      v0 = vcnt;
      frame(VECS[k].b0, VECS[k].b1, VECS[k].b2, int'(VECS[k].n), rx, oe, st);
      chk((vcnt - v0) == int'(VECS[k].exp), $sformatf("R8 R10 R5 R6 vector %0d strobe count", k),
          vcnt - v0, VECS[k].exp);
      if (VECS[k].exp)
        chk({v_op, v_pot, v_addr, v_data} == {VECS[k].op, VECS[k].pot, VECS[k].addr, VECS[k].data},
            $sformatf("R1 vector %0d fields", k),
            {v_op, v_pot, v_addr, v_data}, {VECS[k].op, VECS[k].pot, VECS[k].addr, VECS[k].data});
    end

    // R9 R2 read wiper, pot 2: {10,000000}^A5 = 25
    v0 = vcnt; r0 = rcnt;
    frame(8'h9A, 8'h00, 8'h00, 2, rx, oe, st);
    chk(rcnt - r0 == 1, "R9 read wiper rd_req", rcnt - r0, 1);
    chk(rx == 8'h25, "R2 read wiper data", rx, 8'h25);
    chk(oe, "R3 oe during read data", oe, 1);
    chk(st, "R2 so stable while sck high", st, 1);
    chk(vcnt == v0, "R8 no cmd_valid for read", vcnt - v0, 0);
    chk(!spi_so_oe, "R3 oe released after cs high", spi_so_oe, 0);

    // R9 read register pot 3 addr 12: {11,010010}^A5 = 77
    r0 = rcnt;
    frame(8'hBB, 8'h12, 8'h00, 3, rx, oe, st);
    chk(rcnt - r0 == 1, "R9 read register rd_req", rcnt - r0, 1);
    chk(rx == 8'h77, "R2 read register data", rx, 8'h77);

    // R6 wrong device read gives no request and no drive
    r0 = rcnt;
    frame(8'h96, 8'h00, 8'h00, 2, rx, oe, st);
    chk(rcnt == r0, "R6 foreign read rd_req", rcnt - r0, 0);
    chk(!oe, "R3 oe for foreign read", oe, 0);

    // R4 cut-off frame then a fresh one
    v0 = vcnt;
    cs_begin();
    for (int i = 7; i >= 4; i--) xfer_bit(VECS[0].b0[i], r, oe, st);
    cs_end();
    chk(vcnt == v0, "R4 aborted frame strobe", vcnt - v0, 0);
    frame(8'hA9, 8'h21, 8'h00, 2, rx, oe, st);
    chk(vcnt - v0 == 1 && v_data == 8'h21, "R4 fresh frame after abort", v_data, 8'h21);

    // R10 frame ending mid-byte
    v0 = vcnt;
    cs_begin();
    xfer_byte(8'hA9, rx, oe, st);
    for (int i = 7; i >= 3; i--) xfer_bit(1'b1, r, oe, st);
    cs_end();
    chk(vcnt == v0, "R10 partial byte", vcnt - v0, 0);

    // R7 pause inside a write register address byte
    v0 = vcnt;
    cs_begin();
    xfer_byte(8'hCB, rx, oe, st);
    for (int i = 7; i >= 5; i--) xfer_bit(logic'((8'h0E >> i) & 1), r, oe, st);
    spi_hold_n = 1'b0;
    wait_clk(HALF);
    for (int j = 0; j < 3; j++) begin
      spi_si = j[0]; spi_sck = 1'b1; wait_clk(HALF);
      spi_sck = 1'b0; wait_clk(HALF);
    end
    spi_hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 4; i >= 0; i--) xfer_bit(logic'((8'h0E >> i) & 1), r, oe, st);
    xfer_byte(8'h99, rx, oe, st);
    cs_end();
    chk(vcnt - v0 == 1 && v_addr == 8'h0E && v_data == 8'h99, "R7 write across pause",
        {v_addr, v_data}, 16'h0E99);

    // R7 R3 pause inside read data: pot 3 addr 2C -> {11,101100}^A5 = 49
    cs_begin();
    xfer_byte(8'hBB, rx, oe, st);
    xfer_byte(8'h2C, rx, oe, st);
    for (int i = 7; i >= 5; i--) begin xfer_bit(1'b0, r, oe, st); rx[i] = r; end
    spi_hold_n = 1'b0;
    wait_clk(HALF);
    chk(!spi_so_oe, "R7 oe low during pause", spi_so_oe, 0);
    spi_sck = 1'b1; wait_clk(HALF); spi_sck = 1'b0; wait_clk(HALF);
    chk(!spi_so_oe, "R3 oe low during pause toggles", spi_so_oe, 0);
    spi_hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 4; i >= 0; i--) begin xfer_bit(1'b0, r, oe, st); rx[i] = r; end
    cs_end();
    chk(rx == 8'h49, "R7 read data across pause", rx, 8'h49);

    // R6 strap change makes the other address match
    strap_addr = 2'b01;
    wait_clk(4);
    v0 = vcnt;
    frame(8'hA5, 8'h11, 8'h00, 2, rx, oe, st);
    chk(vcnt - v0 == 1 && v_pot == 2'd1 && v_data == 8'h11, "R6 new strap accepted",
        {v_pot, v_data}, {2'd1, 8'h11});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule